// File: doc/BRIEF.md
# Region-Masked Write-Protected RAM

A single-port synchronous byte RAM for an 8-bit processor bus. The RAM is split into equal regions, and each region has one enable bit in an internal mask register. A RAM write lands only when the enable bit of its region is set. Any other write is dropped, and a fault pulse tells the system that a task stepped outside its memory.

The mask register is selected with `maskSel` rather than by the RAM address decode. It can be read back at any time. It can be changed only while the processor's privilege (interrupt) bit is high, so unprivileged code cannot unlock memory for itself. A parameter turns the protection off, and the block then acts as plain RAM.

Top module: `rgn_guard_ram`

## Requirements
- R1: The region of an access is the top `REGION_BITS` bits of `busAddr`. The default is a 1 KB array (`ADDR_W`=10) with 16 regions of 64 bytes, selected by bits [9:6]. `ADDR_W`=12 with `REGION_BITS`=5 gives 32 regions of 128 bytes, selected by bits [11:7].
- R2: With protection on, a RAM write (`wrEn`=1, `maskSel`=0) changes memory only when the mask bit of its region is 1. Mask bit i enables region i. Mask byte k holds regions 8k to 8k+7, with bit 0 being the lowest region.
- R3: A mask write (`wrEn`=1, `maskSel`=1) loads `wrData` into the mask byte numbered by the low bits of `busAddr`, but only while `privIn`=1. Otherwise the mask is unchanged.
- R4: With protection on, each blocked write drives `wrFault` high for exactly the cycle after it. A blocked write is a RAM write to a masked region, or a mask write with `privIn`=0. Back-to-back blocked writes keep `wrFault` high, and `wrFault` is 0 after any cycle without one.
- R5: With `PROTECT_EN`=0, every RAM write commits whatever the mask holds, and `wrFault` stays 0.
- R6: Reset clears the mask to all zeros, which protects every region, and drives `rdData` and `wrFault` to 0.
- R7: With `rdEn`=1, `rdData` shows the RAM byte (`maskSel`=0) or the mask byte (`maskSel`=1) one cycle later. With `rdEn`=0 it holds its value. Reads are never blocked by the mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| privIn | input | 1 | Processor privilege bit; permits mask writes |
| busAddr | input | ADDR_W | Byte address, or mask byte index when maskSel=1 |
| wrData | input | 8 | Write data |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| maskSel | input | 1 | Target the mask register instead of the RAM |
| rdData | output | 8 | Registered read data |
| wrFault | output | 1 | One-cycle pulse after a blocked write |

## Verification
The main writes are run first with every region open and then with a sparse mask (regions 0, 2 and 15). Comparing the two runs separates a region decode that is wrong from a gate that is wrong. Writes on either side of the boundary at 0x03F/0x040, and to the last byte 0x3FF, show that the region is taken from the right address bits. Mask writes with the privilege bit low and then high separate the privilege gate from the mask data path. A second instance with protection off gets the same stimulus, so a blocked write must leave different read data in the two instances. Back-to-back blocked writes followed by idle cycles show that the fault is a pulse and not a sticky flag.

// File: rtl/rgn_ram_pkg.sv
package rgn_ram_pkg;
  typedef struct packed {
    logic ramWe;
    logic maskWe;
    logic rdRam;
    logic rdMask;
  } ramStrobe_t;
endpackage

// File: rtl/rgn_ram_ctrl.sv
module rgn_ram_ctrl
  import rgn_ram_pkg::*;
#(
  parameter bit PROTECT_EN = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic       maskSel,
  input  logic       privIn,
  input  logic       regionOpen,
  output ramStrobe_t st,
  output logic       wrFault
);
  logic blockedNow;

  always_comb begin
    st.ramWe  = wrEn && !maskSel && (regionOpen || !PROTECT_EN);
    st.maskWe = wrEn && maskSel && privIn;
    st.rdRam  = rdEn && !maskSel;
    st.rdMask = rdEn && maskSel;
    blockedNow = PROTECT_EN && wrEn && (maskSel ? !privIn : !regionOpen);
  end

  always_ff @(posedge clk) begin
    if (rst) wrFault <= 1'b0;
    else     wrFault <= blockedNow;
  end

  // R4: a fault pulse only ever follows a write strobe
  a_r4_fault_after_write: assert property (@(posedge clk) disable iff (rst)
    wrFault |-> $past(wrEn));

  // R5: unprotected variant never reports a fault
  a_r5_open_quiet: assert property (@(posedge clk) disable iff (rst)
    $past(wrEn) && !PROTECT_EN |-> !wrFault);
endmodule

// File: rtl/rgn_ram_dp.sv
module rgn_ram_dp
  import rgn_ram_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int REGION_BITS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  ramStrobe_t        st,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        wrData,
  output logic              regionOpen,
  output logic [7:0]        rdData
);
  localparam int DEPTH      = 1 << ADDR_W;
  localparam int REGIONS    = 1 << REGION_BITS;
  localparam int MASK_BYTES = REGIONS / 8;
  localparam int SEL_W      = $clog2(MASK_BYTES);

  logic [7:0]             mem [DEPTH];
  logic [REGIONS-1:0]     maskQ;
  logic [REGION_BITS-1:0] regionIdx;
  logic [SEL_W-1:0]       maskByte;

  assign regionIdx  = busAddr[ADDR_W-1 -: REGION_BITS];
  assign maskByte   = busAddr[SEL_W-1:0];
  assign regionOpen = maskQ[regionIdx];

  always_ff @(posedge clk) begin
    if (st.ramWe) mem[busAddr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (rst)            maskQ <= '0;
    else if (st.maskWe) maskQ[maskByte*8 +: 8] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (rst)            rdData <= '0;
    else if (st.rdRam)  rdData <= mem[busAddr];
    else if (st.rdMask) rdData <= maskQ[maskByte*8 +: 8];
  end

  // R2: an accepted write is present in the array after the edge
  a_r2_commit: assert property (@(posedge clk) disable iff (rst)
    st.ramWe |=> mem[$past(busAddr)] == $past(wrData));

  // R3: the mask moves only on a granted mask write (or reset)
  a_r3_mask_gated: assert property (@(posedge clk) disable iff (rst)
    !$stable(maskQ) |-> $past(rst) || $past(st.maskWe));

  // R7: read data changes only after a read strobe (or reset)
  a_r7_rd_hold: assert property (@(posedge clk) disable iff (rst)
    !$stable(rdData) |-> $past(rst) || $past(st.rdRam || st.rdMask));
endmodule

// File: rtl/rgn_guard_ram.sv
module rgn_guard_ram
  import rgn_ram_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int REGION_BITS = 4,
  parameter bit PROTECT_EN  = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              privIn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        wrData,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic              maskSel,
  output logic [7:0]        rdData,
  output logic              wrFault
);
  ramStrobe_t st;
  logic       regionOpen;

  rgn_ram_ctrl #(.PROTECT_EN(PROTECT_EN)) u_ctrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .rdEn(rdEn), .maskSel(maskSel),
    .privIn(privIn), .regionOpen(regionOpen), .st(st), .wrFault(wrFault)
  );

  rgn_ram_dp #(.ADDR_W(ADDR_W), .REGION_BITS(REGION_BITS)) u_dp (
    .clk(clk), .rst(rst), .st(st), .busAddr(busAddr), .wrData(wrData),
    .regionOpen(regionOpen), .rdData(rdData)
  );
endmodule

// File: tb/rgn_guard_ram_tb.sv
`timescale 1ns/1ps
module rgn_guard_ram_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic privIn = 1'b0, wrEn = 1'b0, rdEn = 1'b0, maskSel = 1'b0;
  logic [9:0] busAddr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdP, rdO;
  logic faultP, faultO;

  always #2 clk = ~clk;

  rgn_guard_ram #(.ADDR_W(10), .REGION_BITS(4), .PROTECT_EN(1'b1)) u_dut (
    .clk(clk), .rst(rst), .privIn(privIn), .busAddr(busAddr), .wrData(wrData),
    .wrEn(wrEn), .rdEn(rdEn), .maskSel(maskSel), .rdData(rdP), .wrFault(faultP));

  rgn_guard_ram #(.ADDR_W(10), .REGION_BITS(4), .PROTECT_EN(1'b0)) u_dut_open (
    .clk(clk), .rst(rst), .privIn(privIn), .busAddr(busAddr), .wrData(wrData),
    .wrEn(wrEn), .rdEn(rdEn), .maskSel(maskSel), .rdData(rdO), .wrFault(faultO));

  typedef struct {
    int         due;
    logic [7:0] rdP;
    logic [7:0] rdO;
    logic       fP;
    string      tag;
  } exp_t;

  exp_t q[$];
  exp_t it;
  int cyc = 0, nChk = 0, nBad = 0;
  logic done = 1'b0;

  logic [15:0] maskM = '0;
  logic [7:0]  memP [1024];
  logic [7:0]  memO [1024];
  logic [7:0]  holdP = '0, holdO = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: compare outputs against queued expectations
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due == cyc) begin
      it = q.pop_front();
      chk(rdP, it.rdP, {it.tag, " rdData"});
      chk({7'd0, faultP}, {7'd0, it.fP}, {it.tag, " wrFault"});
      chk(rdO, it.rdO, {it.tag, " open rdData"});
      chk({7'd0, faultO}, 8'd0, {it.tag, " R5 open wrFault"});
    end
  end

  // driver: apply one bus cycle and push the expected result
  task automatic op(input logic we, input logic re, input logic sel, input logic pv,
                    input logic [9:0] a, input logic [7:0] d, input string tag);
    exp_t e;
    logic f;
    @(negedge clk);
    wrEn = we; rdEn = re; maskSel = sel; privIn = pv; busAddr = a; wrData = d;
    f = 1'b0;
    if (re) begin
      holdP = sel ? maskM[a[0]*8 +: 8] : memP[a];
      holdO = sel ? maskM[a[0]*8 +: 8] : memO[a];
    end
    if (we && !sel) begin
      if (maskM[a[9:6]]) memP[a] = d;
      else f = 1'b1;
      memO[a] = d;
    end
    if (we && sel) begin
      if (pv) maskM[a[0]*8 +: 8] = d;
      else f = 1'b1;
    end
    e.due = cyc + 1; e.rdP = holdP; e.rdO = holdO; e.fP = f; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(input string tag);
    op(1'b0, 1'b0, 1'b0, 1'b0, 10'h000, 8'h00, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(rdP, 8'h00, "R6 reset rdData");
    chk({7'd0, faultP}, 8'd0, "R6 reset wrFault");

    op(0, 1, 1, 0, 10'd0, 8'h00, "R6 mask byte0 after reset");
    op(0, 1, 1, 0, 10'd1, 8'h00, "R6 mask byte1 after reset");
    op(1, 0, 1, 0, 10'd0, 8'hFF, "R3 R4 unprivileged mask write");
    op(0, 1, 1, 0, 10'd0, 8'h00, "R3 mask unchanged");
    op(1, 0, 1, 1, 10'd0, 8'hFF, "R3 privileged mask write b0");
    op(1, 0, 1, 1, 10'd1, 8'hFF, "R3 privileged mask write b1");
    op(0, 1, 1, 0, 10'd1, 8'h00, "R3 R7 mask readback");

    op(1, 0, 0, 0, 10'h03F, 8'h3C, "R2 fill");
    op(1, 0, 0, 0, 10'h040, 8'h40, "R2 fill");
    op(1, 0, 0, 0, 10'h080, 8'h81, "R2 fill");
    op(1, 0, 0, 0, 10'h0BF, 8'hBF, "R2 fill");
    op(1, 0, 0, 0, 10'h0C0, 8'hC0, "R2 fill");
    op(1, 0, 0, 0, 10'h100, 8'h10, "R2 fill");
    op(1, 0, 0, 0, 10'h3FF, 8'hEE, "R2 fill");
    op(0, 1, 0, 0, 10'h040, 8'h00, "R7 read filled");

    op(1, 0, 1, 1, 10'd0, 8'h05, "R3 sparse mask b0");
    op(1, 0, 1, 1, 10'd1, 8'h80, "R3 sparse mask b1");

    op(1, 0, 0, 0, 10'h040, 8'h11, "R1 R2 R4 region1 blocked");
    op(1, 0, 0, 0, 10'h03F, 8'hC3, "R1 R2 region0 last byte");
    op(1, 0, 0, 0, 10'h3FF, 8'h77, "R1 R2 region15");
    op(1, 0, 0, 0, 10'h0BF, 8'hB0, "R2 region2");
    op(1, 0, 0, 0, 10'h0C0, 8'h0C, "R4 back-to-back blocked 1");
    op(1, 0, 0, 0, 10'h100, 8'h01, "R4 back-to-back blocked 2");
    idle("R4 fault pulse ends");
    idle("R4 fault stays low");

    op(0, 1, 0, 0, 10'h040, 8'h00, "R2 R5 R7 read blocked addr");
    op(0, 1, 0, 0, 10'h03F, 8'h00, "R1 R7 read region0");
    op(0, 1, 0, 0, 10'h3FF, 8'h00, "R1 R7 read region15");
    op(0, 1, 0, 0, 10'h0BF, 8'h00, "R7 read region2");
    op(0, 1, 0, 0, 10'h0C0, 8'h00, "R2 R5 read region3");
    op(0, 1, 0, 0, 10'h100, 8'h00, "R2 R5 read region4");
    idle("R7 rdData holds");
    idle("R7 rdData holds");
    op(0, 1, 1, 0, 10'd0, 8'h00, "R7 mask read b0");
    op(0, 1, 1, 0, 10'd1, 8'h00, "R7 mask read b1");
    idle("R7 drain");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      nChk++; nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
      $finish;
    end
  end
endmodule